// File: doc/BRIEF.md
# Nanosecond Alarm Timer

This peripheral keeps a free-running 64-bit time count in nanoseconds and compares it against a one-shot alarm value. When the alarm time is reached the block raises a level interrupt. It sits on a simple 32-bit register bus with a select, a write enable, a byte address and write data. Read data comes back registered on the cycle after the read.

Software reads the time in two halves. Reading the low half also freezes the matching high half, so the two words read afterwards form one coherent 64-bit sample. To set an alarm, software stages the upper half first and then writes the lower half. The write of the lower half loads the full compare value and arms the alarm.

An armed alarm whose value is less than or equal to the count disarms itself and sets a sticky pending flag. The flag is held until software clears it. The interrupt line is the pending flag gated by an enable bit. The count advances by a parameter `STEP` on every clock and wraps modulo 2^64.

Top module: `ns_alarm_timer`

## Requirements
- R1: Reset clears the count. After reset the count increases by `STEP` on every clock, modulo 2^64.
- R2: A read of byte offset 0x00 returns the low 32 bits of the live count. In the same cycle it captures the upper 32 bits of that count into a holding word.
- R3: A read of offset 0x04 returns the holding word from the most recent 0x00 read, not the live upper bits.
- R4: A write to offset 0x0C only stages the upper alarm half. It does not arm the alarm.
- R5: A write to offset 0x08 loads the alarm value as {staged upper, written lower} and arms the alarm. Offset 0x18 then reads 1 in bit 0.
- R6: Take C as the count in the cycle before a clock edge. At the first edge where an armed alarm value is less than or equal to C, the alarm disarms (0x18 reads 0) and the pending flag sets. An alarm already in the past therefore fires on the edge after the arming write.
- R7: Bit 0 written to offset 0x10 sets the enable, and reading 0x10 returns it in bit 0. The interrupt output equals pending AND enable. Pending stays set while the enable is 0, so the interrupt appears as soon as enable goes to 1.
- R8: Any write to offset 0x14 disarms the alarm, so no interrupt follows when its time passes.
- R9: Any write to offset 0x1C clears the pending flag, and the interrupt drops on the same edge.
- R10: The following reads return 0: offsets 0x08, 0x0C, 0x14 and 0x1C, any address at 0x20 or above, and any address whose low two bits are not 0. Writes to 0x00, 0x04 and 0x18 change nothing.
- R11: Read data appears on `bus_rdata` on the cycle after the read, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe for one cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | WORD_W | Write data |
| bus_rdata | output | WORD_W | Registered read data |
| irq | output | 1 | Level interrupt, pending AND enable |

## Verification
The assertions assume that every access lasts exactly one cycle and that 0x08 and 0x14 are never written in the same cycle. They also assume that reset is held for more than one clock before the count is checked against its previous value. The bench drives each access for a single cycle, starting and ending on the falling edge. It holds reset for several clocks. It chooses alarm values as exact multiples of `STEP` ahead of a known cycle, so the edge on which the alarm fires is known in advance. A `STEP` that carries into the upper half on every clock makes the held upper word differ visibly from the live one.

// File: rtl/ns_alarm_timer_pkg.sv
package ns_alarm_timer_pkg;

  typedef enum logic [2:0] {
    SEL_TIME_LO  = 3'd0,
    SEL_TIME_HI  = 3'd1,
    SEL_ALM_LO   = 3'd2,
    SEL_ALM_HI   = 3'd3,
    SEL_IRQ_EN   = 3'd4,
    SEL_ALM_CLR  = 3'd5,
    SEL_ALM_STAT = 3'd6,
    SEL_IRQ_CLR  = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic time_lo_rd;
    logic alm_lo_wr;
    logic alm_hi_wr;
    logic irq_en_wr;
    logic alm_clr_wr;
    logic irq_clr_wr;
  } bus_evt_t;

endpackage

// File: rtl/ns_alarm_timer_count.sv
module ns_alarm_timer_count #(
  parameter int WORD_W = 32,
  parameter logic [2*WORD_W-1:0] STEP = 1,
  localparam int CNT_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snap,
  output logic [CNT_W-1:0]  cnt,
  output logic [WORD_W-1:0] hold_hi
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      hold_hi <= '0;
    end else begin
      cnt <= cnt + STEP;
      if (snap) hold_hi <= cnt[CNT_W-1:WORD_W];
    end
  end

endmodule

// File: rtl/ns_alarm_timer_alarm.sv
module ns_alarm_timer_alarm
  import ns_alarm_timer_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int CNT_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_evt_t          evt,
  input  logic [WORD_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  alarm,
  output logic              armed,
  output logic              pend,
  output logic              en,
  output logic              irq
);

  logic [WORD_W-1:0] stage_hi;
  logic              fire;
  logic              armed_n;
  logic              pend_n;
  logic              en_n;

  always_comb begin
    fire    = armed && (alarm <= cnt) && !evt.alm_clr_wr;
    armed_n = armed;
    if (fire || evt.alm_clr_wr) armed_n = 1'b0;
    if (evt.alm_lo_wr)          armed_n = 1'b1;
    pend_n = pend;
    if (evt.irq_clr_wr) pend_n = 1'b0;
    if (fire)           pend_n = 1'b1;
    en_n = evt.irq_en_wr ? wdata[0] : en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_hi <= '0;
      alarm    <= '0;
      armed    <= 1'b0;
      pend     <= 1'b0;
      en       <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (evt.alm_hi_wr) stage_hi <= wdata;
      if (evt.alm_lo_wr) alarm <= {stage_hi, wdata};
      armed <= armed_n;
      pend  <= pend_n;
      en    <= en_n;
      irq   <= pend_n & en_n;
    end
  end

endmodule

// File: rtl/ns_alarm_timer_bus.sv
module ns_alarm_timer_bus
  import ns_alarm_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] time_lo,
  input  logic [WORD_W-1:0] hold_hi,
  input  logic              en,
  input  logic              armed,
  output bus_evt_t          evt,
  output logic [WORD_W-1:0] rdata
);

  localparam int IDX_LSB = 2;
  localparam int IDX_MSB = 4;

  logic     upper_zero;
  logic     hit;
  reg_sel_e idx;
  logic     rd;
  logic     wr;

  generate
    if (ADDR_W > IDX_MSB + 1) begin : g_upper
      assign upper_zero = (addr[ADDR_W-1:IDX_MSB+1] == '0);
    end else begin : g_exact
      assign upper_zero = 1'b1;
    end
  endgenerate

  assign hit = upper_zero && (addr[IDX_LSB-1:0] == '0);
  assign idx = reg_sel_e'(addr[IDX_MSB:IDX_LSB]);
  assign rd  = sel && !we && hit;
  assign wr  = sel && we && hit;

  always_comb begin
    evt.time_lo_rd = rd && (idx == SEL_TIME_LO);
    evt.alm_lo_wr  = wr && (idx == SEL_ALM_LO);
    evt.alm_hi_wr  = wr && (idx == SEL_ALM_HI);
    evt.irq_en_wr  = wr && (idx == SEL_IRQ_EN);
    evt.alm_clr_wr = wr && (idx == SEL_ALM_CLR);
    evt.irq_clr_wr = wr && (idx == SEL_IRQ_CLR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (sel && !we) begin
      rdata <= '0;
      if (hit) begin
        case (idx)
          SEL_TIME_LO:  rdata <= time_lo;
          SEL_TIME_HI:  rdata <= hold_hi;
          SEL_IRQ_EN:   rdata <= {{(WORD_W-1){1'b0}}, en};
          SEL_ALM_STAT: rdata <= {{(WORD_W-1){1'b0}}, armed};
          default:      rdata <= '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/ns_alarm_timer.sv
module ns_alarm_timer
  import ns_alarm_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 32,
  parameter logic [2*WORD_W-1:0] STEP = 1,
  localparam int CNT_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq
);

  bus_evt_t          evt_w;
  logic [CNT_W-1:0]  cnt_w;
  logic [CNT_W-1:0]  alarm_w;
  logic [WORD_W-1:0] hold_w;
  logic              armed_w;
  logic              pend_w;
  logic              en_w;

  ns_alarm_timer_bus #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_bus (
    .clk     (clk),
    .rst     (rst),
    .sel     (bus_sel),
    .we      (bus_we),
    .addr    (bus_addr),
    .time_lo (cnt_w[WORD_W-1:0]),
    .hold_hi (hold_w),
    .en      (en_w),
    .armed   (armed_w),
    .evt     (evt_w),
    .rdata   (bus_rdata)
  );

  ns_alarm_timer_count #(.WORD_W(WORD_W), .STEP(STEP)) u_count (
    .clk     (clk),
    .rst     (rst),
    .snap    (evt_w.time_lo_rd),
    .cnt     (cnt_w),
    .hold_hi (hold_w)
  );

  ns_alarm_timer_alarm #(.WORD_W(WORD_W)) u_alarm (
    .clk   (clk),
    .rst   (rst),
    .evt   (evt_w),
    .wdata (bus_wdata),
    .cnt   (cnt_w),
    .alarm (alarm_w),
    .armed (armed_w),
    .pend  (pend_w),
    .en    (en_w),
    .irq   (irq)
  );

endmodule

// File: rtl/ns_alarm_timer_chk.sv
module ns_alarm_timer_chk
  import ns_alarm_timer_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter logic [2*WORD_W-1:0] STEP = 1,
  localparam int CNT_W = 2 * WORD_W
) (
  input logic             clk,
  input logic             rst,
  input bus_evt_t         evt,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] alarm,
  input logic             armed,
  input logic             pend,
  input logic             en,
  input logic             irq
);

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cnt == $past(cnt) + STEP);

  // R4
  hi_noarm_chk: assert property (@(posedge clk) disable iff (rst)
    (evt.alm_hi_wr && !armed) |=> !armed);

  // R5
  arm_chk: assert property (@(posedge clk) disable iff (rst)
    evt.alm_lo_wr |=> armed);

  // R6
  fire_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && (alarm <= cnt) && !evt.alm_clr_wr && !evt.alm_lo_wr) |=> (pend && !armed));

  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (en && pend));

  // R8
  clr_alarm_chk: assert property (@(posedge clk) disable iff (rst)
    evt.alm_clr_wr |=> !armed);

  // R9
  clr_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (evt.irq_clr_wr && !armed) |=> !irq);

endmodule

bind ns_alarm_timer ns_alarm_timer_chk #(.WORD_W(WORD_W), .STEP(STEP)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .evt   (evt_w),
  .cnt   (cnt_w),
  .alarm (alarm_w),
  .armed (armed_w),
  .pend  (pend_w),
  .en    (en_w),
  .irq   (irq)
);

// File: tb/sim_ns_alarm_timer.sv
module sim_ns_alarm_timer;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int WORD_W = 32;
  localparam logic [63:0] STEP = 64'h0000_0001_0000_0001;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_sel = 1'b0;
  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [WORD_W-1:0] bus_wdata = '0;
  logic [WORD_W-1:0] bus_rdata;
  logic              irq;

  int          n_cmp = 0;
  int          n_bad = 0;
  logic [63:0] cyc = '0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= '0;
    else     cyc <= cyc + 64'd1;
  end

  ns_alarm_timer #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .STEP(STEP)) u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [WORD_W-1:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [WORD_W-1:0] d,
                    output logic [63:0] at);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    at = cyc;
    @(negedge clk);
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [63:0] model(input logic [63:0] c);
    return c * STEP;
  endfunction

  task automatic t_reset();
    check("R1 rdata at reset", {32'd0, bus_rdata}, 64'd0);
    check("R7 irq at reset", {63'd0, irq}, 64'd0);
  endtask

  task automatic t_count();
    logic [31:0] d; logic [63:0] at; logic [63:0] m;
    rd(8'h00, d, at); m = model(at);
    check("R1 R2 time low first", {32'd0, d}, {32'd0, m[31:0]});
    idle(5);
    rd(8'h00, d, at); m = model(at);
    check("R1 R2 time low later", {32'd0, d}, {32'd0, m[31:0]});
    idle(2);
    check("R11 read data held", {32'd0, bus_rdata}, {32'd0, m[31:0]});
  endtask

  task automatic t_coherent();
    logic [31:0] d; logic [63:0] at; logic [63:0] m;
    rd(8'h00, d, at); m = model(at);
    idle(4);
    rd(8'h04, d, at);
    check("R3 held high word", {32'd0, d}, {32'd0, m[63:32]});
  endtask

  task automatic t_future_alarm();
    logic [31:0] d; logic [63:0] at; logic [63:0] k; logic [63:0] a;
    wr(8'h10, 32'd1);
    k = cyc; a = model(k + 64'd14);
    wr(8'h0C, a[63:32]);
    rd(8'h18, d, at);
    check("R4 high write does not arm", {32'd0, d}, 64'd0);
    wr(8'h08, a[31:0]);
    rd(8'h18, d, at);
    check("R5 status armed", {32'd0, d}, 64'd1);
    while (cyc < k + 64'd14) @(negedge clk);
    check("R6 no irq before alarm", {63'd0, irq}, 64'd0);
    @(negedge clk);
    check("R6 irq on alarm edge", {63'd0, irq}, 64'd1);
    rd(8'h18, d, at);
    check("R6 disarmed after fire", {32'd0, d}, 64'd0);
    wr(8'h1C, 32'd1);
    check("R9 irq cleared", {63'd0, irq}, 64'd0);
  endtask

  task automatic t_past_alarm();
    wr(8'h0C, 32'd0);
    wr(8'h08, 32'd0);
    check("R6 past alarm not yet", {63'd0, irq}, 64'd0);
    @(negedge clk);
    check("R6 past alarm next cycle", {63'd0, irq}, 64'd1);
    wr(8'h1C, 32'd1);
    check("R9 clear after past alarm", {63'd0, irq}, 64'd0);
  endtask

  task automatic t_enable_gate();
    logic [31:0] d; logic [63:0] at;
    wr(8'h10, 32'd0);
    rd(8'h10, d, at);
    check("R7 enable reads 0", {32'd0, d}, 64'd0);
    wr(8'h0C, 32'd0);
    wr(8'h08, 32'd0);
    idle(3);
    check("R7 masked irq", {63'd0, irq}, 64'd0);
    wr(8'h10, 32'd1);
    check("R7 sticky pending shows", {63'd0, irq}, 64'd1);
    rd(8'h10, d, at);
    check("R7 enable reads 1", {32'd0, d}, 64'd1);
    wr(8'h1C, 32'd1);
    wr(8'h10, 32'd0);
    wr(8'h10, 32'd1);
    check("R9 pending gone after clear", {63'd0, irq}, 64'd0);
  endtask

  task automatic t_clear_alarm();
    logic [31:0] d; logic [63:0] at; logic [63:0] k; logic [63:0] a;
    k = cyc; a = model(k + 64'd12);
    wr(8'h0C, a[63:32]);
    wr(8'h08, a[31:0]);
    wr(8'h14, 32'd1);
    rd(8'h18, d, at);
    check("R8 status after clear", {32'd0, d}, 64'd0);
    while (cyc < k + 64'd18) @(negedge clk);
    check("R8 no irq after clear", {63'd0, irq}, 64'd0);
  endtask

  task automatic t_map();
    logic [31:0] d; logic [63:0] at; logic [63:0] m;
    rd(8'h08, d, at); check("R10 alarm low reads 0", {32'd0, d}, 64'd0);
    rd(8'h0C, d, at); check("R10 alarm high reads 0", {32'd0, d}, 64'd0);
    rd(8'h14, d, at); check("R10 clear alarm reads 0", {32'd0, d}, 64'd0);
    rd(8'h1C, d, at); check("R10 clear irq reads 0", {32'd0, d}, 64'd0);
    rd(8'h20, d, at); check("R10 unmapped reads 0", {32'd0, d}, 64'd0);
    rd(8'h02, d, at); check("R10 misaligned reads 0", {32'd0, d}, 64'd0);
    wr(8'h18, 32'd1);
    rd(8'h18, d, at); check("R10 status write ignored", {32'd0, d}, 64'd0);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, d, at); m = model(at);
    check("R10 time write ignored", {32'd0, d}, {32'd0, m[31:0]});
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    idle(2);
    t_count();
    t_coherent();
    t_future_alarm();
    t_past_alarm();
    t_enable_gate();
    t_clear_alarm();
    t_map();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule